// File: doc/BRIEF.md
# Dual-Channel Storage Controller Register Bank

This block is the memory-mapped register bank of a two-channel disk controller with bus-master DMA. It decodes a 512-byte window on a simple single-cycle read/write bus. For each channel it holds a DMA command byte, a DMA status byte, a 6-bit scratch byte, a 12-bit serial-control word and a 16-bit interrupt-enable field. It also derives a read-only configuration word, in which bit 11 latches the channel interrupt, and a serial-status word that reports whether a drive is present. Two composite read words pack both channels' DMA state into one 32-bit access.

Task-file, device-control and DMA-address offsets are not stored here. They go out on a downstream request port that carries the channel, a kind code, a local offset, the size and the write data, and the answer is placed on the read bus. The two channel interrupt inputs are latched and ORed onto one interrupt output. A write to a serial-control word with bit 0 set sends a one-cycle reset pulse to that channel's drive bus.

A read is answered by a small response state machine. In state RSP_IDLE no data is valid. A local read moves it to RSP_LOCAL, where registered register data is driven. A forwarded read moves it to RSP_FWD, where the downstream response is driven. From any state, a cycle with no read returns it to RSP_IDLE. Back-to-back reads move straight between RSP_LOCAL and RSP_FWD.

Top module: `stor_regbank`

## Requirements
- R1: After reset, the command, status, scratch, serial-control and interrupt-enable registers read 0. Both configuration words read 0x65150000. irq_out, bus_rvalid and chan_bus_rst are 0.
- R2: bus_rvalid rises in the cycle after a read strobe and is 0 in any other cycle. Offsets 0x03, 0x0B, the write-only aliases and every unmapped offset read 0. Writes to unmapped or read-only offsets change nothing.
- R3: The scratch byte (read at 0x01 / 0x09, written there or at 0x11 / 0x19) keeps only data bits 5:0. Bits 7:6 read 0.
- R4: A status write (0x02 / 0x12 for channel 0, 0x0A / 0x1A for channel 1) sets bits 6:5 from the data and keeps bit 0. It clears bits 2:1 where the data bit is 1 and keeps them where it is 0. All other bits become 0.
- R5: dma_evt bits [3c+2:3c] set status bits 2:0 of channel c, and a set wins over a clear in the same cycle. A command write with data bit 0 equal to 0 clears status bit 0.
- R6: A read at 0x10 returns channel-0 command in bits 7:0, with bit 4 ORed with channel 0's latched interrupt and bit 6 ORed with channel 1's latched interrupt. Bit 14 holds channel-1 status bit 2, bits 23:16 hold channel-0 status and bits 31:24 hold channel-1 status.
- R7: A read at 0x18 returns channel-1 command in bits 7:0 with bit 4 ORed with channel 1's latched interrupt, and channel-1 status in bits 23:16.
- R8: irq_in[c] is sampled into bit 11 of channel c's configuration word (0xA0 / 0xE0). irq_out is the OR of the two latched bits.
- R9: The serial-control word (0x100 / 0x180) keeps data bits 11:0. A write with data bit 0 set drives chan_bus_rst[c] high for the single following cycle.
- R10: The interrupt-enable field is written from data bits 31:16 at 0x148 / 0x1C8, masked with 0x3EED, and reads back in bits 31:16.
- R11: The serial-status word (0x104 / 0x184) reads 0x113 when drive_present[c] is 1 and 0 otherwise.
- R12: Accesses at 0x80-0x87 / 0xC0-0xC7 (kind 0, offset addr[2:0]), 0x8A / 0xCA (kind 1, offset 2) and 0x04-0x07 / 0x0C-0x0F (kind 2, offset addr[1:0]) raise fwd_req in the strobe cycle. The request carries the channel, we, size and wdata. A forwarded read returns fwd_rdata as sampled in the response cycle.
- R13: The command byte stores all 8 data bits. It is written at 0x00 or 0x10 for channel 0 and at 0x08 or 0x18 for channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 1 | 0 = byte, 1 = 32-bit word |
| bus_addr | input | 9 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, cycle after the strobe |
| bus_rdata | output | 32 | Read data |
| irq_in | input | 2 | Per-channel interrupt level |
| dma_evt | input | 6 | Per-channel status set bits (3 per channel) |
| drive_present | input | 2 | Per-channel drive-present level |
| irq_out | output | 1 | Shared interrupt |
| chan_bus_rst | output | 2 | Per-channel drive-bus reset pulse |
| fwd_req | output | 1 | Downstream request |
| fwd_we | output | 1 | Downstream write |
| fwd_chan | output | 1 | Downstream channel |
| fwd_kind | output | 2 | 0 task file, 1 control, 2 DMA address |
| fwd_off | output | 3 | Local offset in the target |
| fwd_size | output | 1 | Access size |
| fwd_wdata | output | 32 | Downstream write data |
| fwd_rdata | input | 32 | Downstream read response, valid the cycle after fwd_req |

## Verification
Read data is due in the cycle after the strobe. Register writes take effect at that edge, so a read issued in the next cycle already sees them. The bus-reset pulse and the latched interrupt, with irq_out, show up one cycle after their cause, and fwd_req with its fields is combinational in the strobe cycle itself. The bench drives at the falling edge and puts each read's expected word into a queue. A monitor pops the queue at every falling edge where bus_rvalid is high, and the side-band outputs are sampled at the first falling edge after the edge that causes them.

// File: rtl/stor_pkg.sv
package stor_pkg;
    localparam int ADDR_W  = 9;
    localparam int DATA_W  = 32;
    localparam int NCH     = 2;
    localparam int EVT_W   = 3;
    localparam int SCTL_W  = 12;
    localparam int IEN_W   = 16;
    localparam int SCR_W   = 6;
    localparam int IRQ_BIT = 11;
    localparam logic [15:0]       CONF_ID      = 16'h6515;
    localparam logic [IEN_W-1:0]  IEN_MASK     = 16'h3EED;
    localparam logic [DATA_W-1:0] SSTAT_ONLINE = 32'h0000_0113;
    localparam logic [7:0]        STAT_WR_MASK = 8'h60;
    localparam logic [7:0]        STAT_W1C     = 8'h06;

    typedef enum logic [3:0] {
        RD_ZERO, RD_CMD, RD_SCR, RD_STAT, RD_MIX0, RD_MIX1,
        RD_CONF, RD_SCTL, RD_SSTAT, RD_IEN, RD_FWD
    } rd_sel_e;

    typedef enum logic [2:0] {
        WR_NONE, WR_CMD, WR_SCR, WR_STAT, WR_SCTL, WR_IEN, WR_FWD
    } wr_sel_e;

    typedef enum logic [1:0] {
        FK_TASK = 2'd0, FK_CTRL = 2'd1, FK_DMAADR = 2'd2, FK_NONE = 2'd3
    } fwd_kind_e;

    typedef enum logic [1:0] {
        RSP_IDLE, RSP_LOCAL, RSP_FWD
    } rsp_state_e;
endpackage

// File: rtl/stor_decode.sv
module stor_decode
    import stor_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output rd_sel_e           rd_sel,
    output wr_sel_e           wr_sel,
    output logic              chan,
    output fwd_kind_e         kind,
    output logic [2:0]        off
);
    always_comb begin
        rd_sel = RD_ZERO;
        wr_sel = WR_NONE;
        kind   = FK_NONE;
        off    = 3'd0;
        // channel bit sits at a different position in each region
        chan   = addr[8] ? addr[7] : (addr[7] ? addr[6] : addr[3]);
        unique case (addr)
            9'h000, 9'h008: begin rd_sel = RD_CMD;  wr_sel = WR_CMD;  end
            9'h001, 9'h009: begin rd_sel = RD_SCR;  wr_sel = WR_SCR;  end
            9'h002, 9'h00A: begin rd_sel = RD_STAT; wr_sel = WR_STAT; end
            9'h010:         begin rd_sel = RD_MIX0; wr_sel = WR_CMD;  end
            9'h018:         begin rd_sel = RD_MIX1; wr_sel = WR_CMD;  end
            9'h011, 9'h019: wr_sel = WR_SCR;
            9'h012, 9'h01A: wr_sel = WR_STAT;
            9'h0A0, 9'h0E0: rd_sel = RD_CONF;
            9'h100, 9'h180: begin rd_sel = RD_SCTL; wr_sel = WR_SCTL; end
            9'h104, 9'h184: rd_sel = RD_SSTAT;
            9'h148, 9'h1C8: begin rd_sel = RD_IEN;  wr_sel = WR_IEN;  end
            9'h08A, 9'h0CA: begin
                rd_sel = RD_FWD; wr_sel = WR_FWD; kind = FK_CTRL; off = 3'd2;
            end
            default: begin
                if (addr[8:4] == 5'b00000 && addr[2] == 1'b1) begin
                    rd_sel = RD_FWD; wr_sel = WR_FWD; kind = FK_DMAADR;
                    off = {1'b0, addr[1:0]};
                end else if (addr[8:7] == 2'b01 && addr[5:3] == 3'b000) begin
                    rd_sel = RD_FWD; wr_sel = WR_FWD; kind = FK_TASK;
                    off = addr[2:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/stor_chan.sv
module stor_chan
    import stor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wr_sel_e           wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_in,
    input  logic [EVT_W-1:0]  evt_set,
    input  logic              drive_present,
    output logic [7:0]        cmd_q,
    output logic [7:0]        scr_q,
    output logic [7:0]        stat_q,
    output logic [SCTL_W-1:0] sctl_q,
    output logic [IEN_W-1:0]  ien_q,
    output logic              irq_lat,
    output logic              bus_rst,
    output logic [DATA_W-1:0] conf_word,
    output logic [DATA_W-1:0] sstat_word
);
    logic [7:0] stat_d;
    logic [7:0] wb;

    assign wb = wdata[7:0];

    always_comb begin
        stat_d = stat_q;
        if (wr_en && wr_sel == WR_STAT) begin
            stat_d = (wb & STAT_WR_MASK) | (stat_q & 8'h01) | (stat_q & ~wb & STAT_W1C);
        end
        if (wr_en && wr_sel == WR_CMD && !wb[0]) begin
            stat_d[0] = 1'b0;
        end
        stat_d[EVT_W-1:0] = stat_d[EVT_W-1:0] | evt_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            scr_q   <= '0;
            stat_q  <= '0;
            sctl_q  <= '0;
            ien_q   <= '0;
            irq_lat <= 1'b0;
            bus_rst <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            irq_lat <= irq_in;
            bus_rst <= wr_en && (wr_sel == WR_SCTL) && wdata[0];
            if (wr_en) begin
                unique case (wr_sel)
                    WR_CMD:  cmd_q  <= wb;
                    WR_SCR:  scr_q  <= {{(8-SCR_W){1'b0}}, wdata[SCR_W-1:0]};
                    WR_SCTL: sctl_q <= wdata[SCTL_W-1:0];
                    WR_IEN:  ien_q  <= wdata[DATA_W-1 -: IEN_W] & IEN_MASK;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        conf_word          = {CONF_ID, 16'h0000};
        conf_word[IRQ_BIT] = irq_lat;
        sstat_word         = drive_present ? SSTAT_ONLINE : '0;
    end

    AST_STAT_BIT0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WR_STAT && !evt_set[0]) |=> (stat_q[0] == $past(stat_q[0]))); // R4
    AST_BUSRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |-> $past(wr_en && wr_sel == WR_SCTL && wdata[0])); // R9
    AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in |=> irq_lat); // R8
endmodule

// File: rtl/stor_regbank.sv
module stor_regbank
    import stor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_size,
    input  logic [8:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        irq_in,
    input  logic [5:0]        dma_evt,
    input  logic [1:0]        drive_present,
    output logic              irq_out,
    output logic [1:0]        chan_bus_rst,
    output logic              fwd_req,
    output logic              fwd_we,
    output logic              fwd_chan,
    output logic [1:0]        fwd_kind,
    output logic [2:0]        fwd_off,
    output logic              fwd_size,
    output logic [31:0]       fwd_wdata,
    input  logic [31:0]       fwd_rdata
);
    rd_sel_e   rd_sel;
    wr_sel_e   wr_sel;
    logic      sel_ch;
    fwd_kind_e kind;
    logic [2:0] off;

    logic [NCH-1:0][7:0]        cmd_v, scr_v, stat_v;
    logic [NCH-1:0][SCTL_W-1:0] sctl_v;
    logic [NCH-1:0][IEN_W-1:0]  ien_v;
    logic [NCH-1:0][DATA_W-1:0] conf_v, sstat_v;
    logic [NCH-1:0]             irq_v;

    logic              rd_fire, wr_fire;
    logic [DATA_W-1:0] local_rd, rdata_q;
    rsp_state_e        state_q, state_d;

    stor_decode u_decode (
        .addr   (bus_addr),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel),
        .chan   (sel_ch),
        .kind   (kind),
        .off    (off)
    );

    assign rd_fire = bus_req && !bus_we;
    assign wr_fire = bus_req && bus_we;

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        stor_chan u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_en         (wr_fire && (sel_ch == 1'(gi))),
            .wr_sel        (wr_sel),
            .wdata         (bus_wdata),
            .irq_in        (irq_in[gi]),
            .evt_set       (dma_evt[gi*EVT_W +: EVT_W]),
            .drive_present (drive_present[gi]),
            .cmd_q         (cmd_v[gi]),
            .scr_q         (scr_v[gi]),
            .stat_q        (stat_v[gi]),
            .sctl_q        (sctl_v[gi]),
            .ien_q         (ien_v[gi]),
            .irq_lat       (irq_v[gi]),
            .bus_rst       (chan_bus_rst[gi]),
            .conf_word     (conf_v[gi]),
            .sstat_word    (sstat_v[gi])
        );
    end

    assign irq_out = |irq_v;

    // downstream port: combinational in the strobe cycle
    assign fwd_req   = bus_req && (bus_we ? (wr_sel == WR_FWD) : (rd_sel == RD_FWD));
    assign fwd_we    = bus_we;
    assign fwd_chan  = sel_ch;
    assign fwd_kind  = kind;
    assign fwd_off   = off;
    assign fwd_size  = bus_size;
    assign fwd_wdata = bus_wdata;

    always_comb begin
        local_rd = '0;
        unique case (rd_sel)
            RD_CMD:   local_rd[7:0] = cmd_v[sel_ch];
            RD_SCR:   local_rd[7:0] = scr_v[sel_ch];
            RD_STAT:  local_rd[7:0] = stat_v[sel_ch];
            RD_MIX0: begin
                local_rd[7:0]   = cmd_v[0];
                local_rd[4]     = cmd_v[0][4] | irq_v[0];
                local_rd[6]     = cmd_v[0][6] | irq_v[1];
                local_rd[14]    = stat_v[1][2];
                local_rd[23:16] = stat_v[0];
                local_rd[31:24] = stat_v[1];
            end
            RD_MIX1: begin
                local_rd[7:0]   = cmd_v[1];
                local_rd[4]     = cmd_v[1][4] | irq_v[1];
                local_rd[23:16] = stat_v[1];
            end
            RD_CONF:  local_rd = conf_v[sel_ch];
            RD_SCTL:  local_rd[SCTL_W-1:0] = sctl_v[sel_ch];
            RD_SSTAT: local_rd = sstat_v[sel_ch];
            RD_IEN:   local_rd[DATA_W-1 -: IEN_W] = ien_v[sel_ch];
            default:  local_rd = '0;
        endcase
    end

    // response state machine: next-state
    always_comb begin
        state_d = RSP_IDLE;
        if (rd_fire) begin
            state_d = (rd_sel == RD_FWD) ? RSP_FWD : RSP_LOCAL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_fire) rdata_q <= local_rd;
        end
    end

    // response state machine: outputs
    always_comb begin
        unique case (state_q)
            RSP_LOCAL: begin bus_rvalid = 1'b1; bus_rdata = rdata_q;   end
            RSP_FWD:   begin bus_rvalid = 1'b1; bus_rdata = fwd_rdata; end
            default:   begin bus_rvalid = 1'b0; bus_rdata = '0;        end
        endcase
    end

    AST_RVALID_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> bus_rvalid); // R2
    AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> !bus_rvalid); // R2
    AST_FWD_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req |-> bus_req); // R12
    AST_IRQ_OUT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_in) |=> irq_out); // R8
endmodule

// File: tb/stor_regbank_bench.sv
module stor_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_size = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_in = '0;
    logic [5:0]  dma_evt = '0;
    logic [1:0]  drive_present = '0;
    logic        irq_out;
    logic [1:0]  chan_bus_rst;
    logic        fwd_req, fwd_we, fwd_chan, fwd_size;
    logic [1:0]  fwd_kind;
    logic [2:0]  fwd_off;
    logic [31:0] fwd_wdata;
    logic [31:0] fwd_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] val; string tag; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    stor_regbank u_stor_regbank (.*);

    // downstream responder: answer encodes the request fields
    always_ff @(posedge clk) begin
        if (fwd_req) fwd_rdata <= 32'h5A00_0000 | {23'b0, fwd_chan, 2'b0, fwd_kind, 1'b0, fwd_off};
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = 1'b1;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.val = exp; e.tag = tag;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = 1'b1;
        exp_q.push_back(e);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    // monitor: compare each response as it appears
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: unexpected rvalid, actual 0x%08h expected none", bus_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, bus_rdata, e.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rvalid", {31'b0, bus_rvalid}, 32'd0);
        chk("R1 irq_out", {31'b0, irq_out}, 32'd0);
        chk("R1 bus_rst", {30'b0, chan_bus_rst}, 32'd0);
        rd(9'h000, 32'h0, "R1 cmd0");
        rd(9'h00A, 32'h0, "R1 stat1");
        rd(9'h0A0, 32'h6515_0000, "R1 conf0");
        rd(9'h0E0, 32'h6515_0000, "R1 conf1");
        rd(9'h100, 32'h0, "R1 sctl0");
        rd(9'h1C8, 32'h0, "R1 ien1");

        // R13 command byte and aliases
        wr(9'h000, 32'h0000_00FF);
        rd(9'h000, 32'h0000_00FF, "R13 cmd0 direct");
        wr(9'h018, 32'h0000_0009);
        rd(9'h008, 32'h0000_0009, "R13 cmd1 alias");

        // R3 scratch
        wr(9'h001, 32'hFFFF_FFFF);
        rd(9'h001, 32'h0000_003F, "R3 scr0");
        wr(9'h019, 32'h0000_00AA);
        rd(9'h009, 32'h0000_002A, "R3 scr1 alias");

        // R5 event set, R4 status write rule
        dma_evt = 6'b000_111;
        @(negedge clk);
        dma_evt = '0;
        rd(9'h002, 32'h0000_0007, "R5 evt set ch0");
        wr(9'h002, 32'h0000_0062);
        rd(9'h002, 32'h0000_0065, "R4 stat mix");
        wr(9'h012, 32'h0000_0004);
        rd(9'h002, 32'h0000_0001, "R4 stat alias w1c");
        wr(9'h000, 32'h0000_0008);
        rd(9'h002, 32'h0000_0000, "R5 cmd stop clears bit0");
        dma_evt = 6'b100_000;
        @(negedge clk);
        dma_evt = '0;
        rd(9'h00A, 32'h0000_0004, "R5 evt set ch1");

        // R8 interrupts, R6/R7 composite words
        irq_in = 2'b10;
        @(negedge clk);
        chk("R8 irq_out ch1", {31'b0, irq_out}, 32'd1);
        rd(9'h0E0, 32'h6515_0800, "R8 conf1 bit11");
        rd(9'h0A0, 32'h6515_0000, "R8 conf0 clear");
        rd(9'h010, 32'h0400_4048, "R6 mix0 irq1");
        rd(9'h018, 32'h0004_0019, "R7 mix1 irq1");
        irq_in = 2'b01;
        @(negedge clk);
        rd(9'h010, 32'h0400_4018, "R6 mix0 irq0");
        rd(9'h018, 32'h0004_0009, "R7 mix1 no irq");
        irq_in = 2'b00;
        @(negedge clk);
        chk("R8 irq_out low", {31'b0, irq_out}, 32'd0);

        // R9 serial control and bus reset
        wr(9'h180, 32'h0000_1FFE);
        chk("R9 no pulse", {30'b0, chan_bus_rst}, 32'd0);
        rd(9'h180, 32'h0000_0FFE, "R9 sctl1");
        wr(9'h100, 32'h0000_A5A5);
        chk("R9 pulse ch0", {30'b0, chan_bus_rst}, 32'd1);
        @(negedge clk);
        chk("R9 pulse ends", {30'b0, chan_bus_rst}, 32'd0);
        rd(9'h100, 32'h0000_05A5, "R9 sctl0");

        // R10 interrupt enable
        wr(9'h148, 32'hFFFF_1234);
        rd(9'h148, 32'h3EED_0000, "R10 ien0");
        wr(9'h1C8, 32'h1234_FFFF);
        rd(9'h1C8, 32'h1224_0000, "R10 ien1");

        // R11 serial status
        drive_present = 2'b01;
        rd(9'h104, 32'h0000_0113, "R11 present");
        rd(9'h184, 32'h0000_0000, "R11 absent");

        // R2 unmapped and read-only
        wr(9'h0A0, 32'hFFFF_FFFF);
        rd(9'h0A0, 32'h6515_0000, "R2 conf write ignored");
        wr(9'h003, 32'hFFFF_FFFF);
        rd(9'h003, 32'h0, "R2 0x03 zero");
        rd(9'h00B, 32'h0, "R2 0x0B zero");
        rd(9'h011, 32'h0, "R2 alias read zero");
        rd(9'h1FC, 32'h0, "R2 unmapped zero");
        rd(9'h001, 32'h0000_003F, "R2 scratch untouched");

        // R12 forwarding
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 9'h083; bus_size = 1'b0;
        #1;
        chk("R12 req task", {25'b0, fwd_req, fwd_we, fwd_chan, fwd_kind, fwd_off[1:0]}, {25'b0, 7'b1_0_0_00_11});
        bus_req = 1'b0;
        #1;
        rd(9'h083, 32'h5A00_0003, "R12 task ch0 read");
        rd(9'h0CA, 32'h5A00_0112, "R12 ctrl ch1 read");
        rd(9'h00E, 32'h5A00_0122, "R12 dma addr ch1 read");
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 9'h005; bus_wdata = 32'hDEAD_BEEF; bus_size = 1'b1;
        #1;
        chk("R12 write fields", {24'b0, fwd_req, fwd_we, fwd_chan, fwd_kind, fwd_off}, {24'b0, 8'b1_1_0_10_001});
        chk("R12 write data", fwd_wdata, 32'hDEAD_BEEF);
        chk("R12 write size", {31'b0, fwd_size}, 32'd1);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;

        repeat (3) @(negedge clk);
        chk("R2 all responses seen", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule